// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides a dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. The dividend is either a full 32-bit value or a 16-bit value. A full dividend is presented as two 16-bit words, a high word and a low word. Two mode inputs choose signed or unsigned arithmetic and the dividend width. All four combinations use one shift-subtract engine that retires one quotient bit per clock. Every operation therefore takes the same number of cycles, whatever its width or sign mode.

The caller raises `start` for one cycle while `busy` is low, with the operands and modes valid in that cycle. The block raises `busy`, iterates, and then pulses `done`. In the `done` cycle the quotient, the remainder and two error flags are valid. They keep their values until the next `done`.

In signed mode the engine divides magnitudes and then corrects the signs: the quotient rounds toward zero and the remainder carries the sign of the dividend. A zero divisor sets a divide-by-zero flag. A quotient that does not fit the selected 16-bit range sets an overflow flag.

Top module: `idiv_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `quot`, `rem`, `div_zero` and `q_ovf` are all 0.
- R2: A `start` seen while `busy` is low is accepted at that clock edge. `busy` is high from the accepting edge until `done` rises, and `done` rises at the 17th edge after the accepting edge. `done` stays high for exactly one cycle, with `busy` low, in every mode.
- R3: `start` while `busy` is high has no effect. The operation in progress completes with its original operands and timing, and no further operation begins.
- R4: With `sgn_mode`=0 and `wide_dvd`=1, `quot` = floor({`dvd_hi`,`dvd_lo`} / `divisor`) and `rem` = the dividend minus `quot`·`divisor`. All values are unsigned.
- R5: With `sgn_mode`=1 and `wide_dvd`=1, the operands are two's complement. `quot` is the true quotient rounded toward zero, and `rem` has the dividend's sign, so that dividend = `quot`·`divisor` + `rem`.
- R6: With `wide_dvd`=0 the dividend is `dvd_lo` alone, sign-extended when `sgn_mode`=1 and zero-extended when `sgn_mode`=0. `dvd_hi` is ignored.
- R7: A `divisor` of 0 gives `div_zero`=1, `q_ovf`=0, `quot`=0 and `rem`=0 in the `done` cycle.
- R8: With a nonzero divisor, a quotient outside 0..65535 (unsigned) or -32768..32767 (signed) gives `q_ovf`=1, `div_zero`=0, `quot`=0 and `rem`=0. A signed quotient of exactly -32768 is valid.
- R9: `quot`, `rem`, `div_zero` and `q_ovf` change only in a cycle where `done` is high, and otherwise hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a divide with the current operands |
| sgn_mode | input | 1 | 1 = signed two's complement, 0 = unsigned |
| wide_dvd | input | 1 | 1 = 32-bit dividend {dvd_hi,dvd_lo}, 0 = 16-bit dividend dvd_lo |
| dvd_hi | input | 16 | Upper word of the dividend |
| dvd_lo | input | 16 | Lower word of the dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; results valid |
| quot | output | 16 | Quotient |
| rem | output | 16 | Remainder |
| div_zero | output | 1 | Divisor was zero |
| q_ovf | output | 1 | Quotient out of 16-bit range |

## Verification
Some properties are checked on every cycle. These are the handshake timing: a single-cycle `done` pulse, a fixed count of 17 busy cycles before it, and `busy` and `done` never high together. Also checked every cycle are the holding of results between pulses and the zeroed outputs under either error flag. The arithmetic itself can only be shown by the bench's scenarios. This covers sign correction across all sign pairs, zero- and sign-extension of short dividends, overflow limits including the signed -32768 edge, and a start request ignored mid-operation. The bench compares each of these against an integer reference model on every clock.

// File: rtl/idiv_pkg.sv
// Shared types for the iterative divider.
// Assumes: consumers import the package; no parameters live here.
package idiv_pkg;

    // Control sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } idiv_state_e;

    // Per-operation facts captured when an operation is accepted.
    typedef struct packed {
        logic sgn;      // signed mode
        logic q_neg;    // quotient must be negated
        logic r_neg;    // remainder must be negated
        logic pre_ovf;  // magnitude quotient exceeds W bits
        logic zero;     // divisor was zero
    } idiv_ctl_t;

endpackage

// File: rtl/idiv_prep.sv
// Operand conditioning: extends a short dividend, takes magnitudes in
// signed mode, and flags a zero divisor or a quotient too wide for W bits.
// Assumes: purely combinational; its outputs are sampled at the accepting edge.
module idiv_prep
    import idiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         sgn_mode,
    input  logic         wide_dvd,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] hi_mag,
    output logic [W-1:0] lo_mag,
    output logic [W-1:0] d_mag,
    output idiv_ctl_t    ctl
);

    localparam int DW = 2 * W;

    logic [W-1:0]  hi_ext;
    logic [DW-1:0] full;
    logic [DW-1:0] full_mag;
    logic          dvd_neg;
    logic          dsr_neg;

    // Build the 2W-bit dividend and both magnitudes.
    always_comb begin
        hi_ext   = wide_dvd ? dvd_hi : {W{sgn_mode & dvd_lo[W-1]}};
        full     = {hi_ext, dvd_lo};
        dvd_neg  = sgn_mode & hi_ext[W-1];
        dsr_neg  = sgn_mode & divisor[W-1];
        full_mag = dvd_neg ? (~full + 1'b1) : full;
        d_mag    = dsr_neg ? (~divisor + 1'b1) : divisor;
        hi_mag   = full_mag[DW-1:W];
        lo_mag   = full_mag[W-1:0];
    end

    // Capture the sign and error facts for the finishing stage.
    always_comb begin
        ctl.sgn     = sgn_mode;
        ctl.q_neg   = dvd_neg ^ dsr_neg;
        ctl.r_neg   = dvd_neg;
        ctl.zero    = (divisor == '0);
        ctl.pre_ovf = (divisor != '0) && (hi_mag >= d_mag);
    end

endmodule

// File: rtl/idiv_core.sv
// Restoring shift-subtract engine on unsigned magnitudes: one quotient bit
// per step. After W steps q_mag holds the quotient and r_mag the remainder.
// Assumes: hi_in < d_in for a meaningful result (overflow is flagged elsewhere).
module idiv_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_mag,
    output logic [W-1:0] r_mag
);

    logic [W-1:0] d_q;
    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic         ge;

    // One trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {r_mag, q_mag[W-1]};
        diff    = shifted - {1'b0, d_q};
        ge      = (shifted >= {1'b0, d_q});
    end

    // Load operands or advance one quotient bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_mag <= '0;
            q_mag <= '0;
            d_q   <= '0;
        end else if (load) begin
            r_mag <= hi_in;
            q_mag <= lo_in;
            d_q   <= d_in;
        end else if (step) begin
            r_mag <= ge ? diff[W-1:0] : shifted[W-1:0];
            q_mag <= {q_mag[W-2:0], ge};
        end
    end

endmodule

// File: rtl/idiv_fix.sv
// Finishing stage: restores signs, applies the signed range limit and
// zeroes the results when an error is flagged.
// Assumes: combinational; q_mag and r_mag are final engine values.
module idiv_fix
    import idiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    input  idiv_ctl_t    ctl,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         div_zero,
    output logic         q_ovf
);

    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    logic sgn_ovf;
    logic bad;

    // Range check and sign restoration.
    always_comb begin
        sgn_ovf  = ctl.sgn && (ctl.q_neg ? (q_mag > NEG_LIMIT) : q_mag[W-1]);
        div_zero = ctl.zero;
        q_ovf    = !ctl.zero && (ctl.pre_ovf || sgn_ovf);
        bad      = div_zero || q_ovf;
        quot     = bad ? '0 : (ctl.q_neg ? (~q_mag + 1'b1) : q_mag);
        rem      = bad ? '0 : (ctl.r_neg ? (~r_mag + 1'b1) : r_mag);
    end

endmodule

// File: rtl/idiv_engine.sv
// Iterative divider top: sequences accept, W engine steps and a finishing
// cycle that registers the results and pulses done.
// Assumes: operands and modes are valid in the cycle start is high.
module idiv_engine
    import idiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sgn_mode,
    input  logic         wide_dvd,
    input  logic [W-1:0] dvd_hi,
    input  logic [W-1:0] dvd_lo,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         div_zero,
    output logic         q_ovf
);

    localparam int           CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    idiv_state_e  state;
    logic [CW-1:0] cnt;
    idiv_ctl_t    ctl_in, ctl_q;
    logic [W-1:0] hi_mag, lo_mag, d_mag;
    logic [W-1:0] q_mag, r_mag;
    logic [W-1:0] quot_n, rem_n;
    logic         zero_n, ovf_n;
    logic         load, step;

    assign load = (state == ST_IDLE) && start;
    assign step = (state == ST_RUN);

    idiv_prep #(.W(W)) u_prep (
        .sgn_mode (sgn_mode),
        .wide_dvd (wide_dvd),
        .dvd_hi   (dvd_hi),
        .dvd_lo   (dvd_lo),
        .divisor  (divisor),
        .hi_mag   (hi_mag),
        .lo_mag   (lo_mag),
        .d_mag    (d_mag),
        .ctl      (ctl_in)
    );

    idiv_core #(.W(W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .hi_in (hi_mag),
        .lo_in (lo_mag),
        .d_in  (d_mag),
        .q_mag (q_mag),
        .r_mag (r_mag)
    );

    idiv_fix #(.W(W)) u_fix (
        .q_mag    (q_mag),
        .r_mag    (r_mag),
        .ctl      (ctl_q),
        .quot     (quot_n),
        .rem      (rem_n),
        .div_zero (zero_n),
        .q_ovf    (ovf_n)
    );

    // Sequencer: idle -> W steps -> finish, with the busy/done handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ctl_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    cnt   <= '0;
                    ctl_q <= ctl_in;
                    busy  <= 1'b1;
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_FIN;
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                    busy  <= 1'b0;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result registers: loaded only in the finishing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot     <= '0;
            rem      <= '0;
            div_zero <= 1'b0;
            q_ovf    <= 1'b0;
        end else if (state == ST_FIN) begin
            quot     <= quot_n;
            rem      <= rem_n;
            div_zero <= zero_n;
            q_ovf    <= ovf_n;
        end
    end

endmodule

// File: rtl/idiv_chk.sv
// Protocol and output checker for idiv_engine, attached by bind.
// Assumes: port names match the top module; W matches the instance.
module idiv_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         sgn_mode,
    input logic         wide_dvd,
    input logic [W-1:0] dvd_hi,
    input logic [W-1:0] dvd_lo,
    input logic [W-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quot,
    input logic [W-1:0] rem,
    input logic         div_zero,
    input logic         q_ovf
);

    localparam int            BW  = $clog2(W + 2) + 1;
    localparam logic [BW-1:0] LAT = BW'(W + 1);

    logic [BW-1:0] bcnt;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= '0;
        else if (busy) bcnt <= bcnt + 1'b1;
        else           bcnt <= '0;
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcnt == LAT));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R7
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> (quot == '0 && rem == '0 && !q_ovf));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_ovf |-> (quot == '0 && rem == '0 && !div_zero));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quot) && $stable(rem) && $stable(div_zero) && $stable(q_ovf)));

endmodule

bind idiv_engine idiv_chk #(.W(W)) u_idiv_chk (.*);

// File: tb/test_idiv_engine.sv
module test_idiv_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sgn_mode = 1'b0;
    logic        wide_dvd = 1'b0;
    logic [15:0] dvd_hi = '0;
    logic [15:0] dvd_lo = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, div_zero, q_ovf;
    logic [15:0] quot, rem;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    bit    checking = 1'b0;
    string cur_req = "R4";

    // reference model state
    int          m_cnt = 0;
    logic        m_busy = 0, m_done = 0, m_z = 0, m_o = 0;
    logic [15:0] m_q = 0, m_r = 0;
    logic [15:0] p_q, p_r;
    logic        p_z, p_o;

    always #5 clk = ~clk;

    idiv_engine i_idiv_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .sgn_mode(sgn_mode),
        .wide_dvd(wide_dvd), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
        .busy(busy), .done(done), .quot(quot), .rem(rem),
        .div_zero(div_zero), .q_ovf(q_ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                     req, what, got, exp, cycles);
        end
    endtask

    function automatic void calc(input logic [15:0] hi, lo, d, input logic sg, wd,
                                 output logic [15:0] q, r, output logic z, o);
        longint a, b, qq, rr;
        if (wd) a = sg ? longint'($signed({hi, lo})) : longint'({hi, lo});
        else    a = sg ? longint'($signed(lo)) : longint'(lo);
        b = sg ? longint'($signed(d)) : longint'(d);
        z = 1'b0; o = 1'b0; q = '0; r = '0;
        if (b == 0) begin
            z = 1'b1;
        end else begin
            qq = a / b;
            rr = a % b;
            if (sg) o = (qq < -32768) || (qq > 32767);
            else    o = (qq > 65535);
            if (!o) begin
                q = qq[15:0];
                r = rr[15:0];
            end
        end
    endfunction

    // Behavioural model: countdown from accept to done.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_busy = 0; m_done = 0;
            m_q = 0; m_r = 0; m_z = 0; m_o = 0;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_done = 1; m_busy = 0;
                m_q = p_q; m_r = p_r; m_z = p_z; m_o = p_o;
            end
        end else begin
            m_done = 0;
            if (start) begin
                calc(dvd_hi, dvd_lo, divisor, sgn_mode, wide_dvd, p_q, p_r, p_z, p_o);
                m_cnt = 17;
                m_busy = 1;
            end
        end
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && checking) begin
            check(busy == m_busy && done == m_done, "R2", "busy/done",
                  {busy, done}, {m_busy, m_done});
            check(quot == m_q && rem == m_r, m_done ? cur_req : "R9", "quot/rem",
                  {quot, rem}, {m_q, m_r});
            check(div_zero == m_z && q_ovf == m_o, m_done ? cur_req : "R9", "flags",
                  {div_zero, q_ovf}, {m_z, m_o});
        end
    end

    task automatic do_op(input logic [15:0] hi, lo, d, input logic sg, wd, input string req);
        @(negedge clk);
        cur_req  = req;
        dvd_hi   = hi; dvd_lo = lo; divisor = d;
        sgn_mode = sg; wide_dvd = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (17) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy, done, div_zero, q_ovf} == 4'b0 && quot == 0 && rem == 0,
              "R1", "reset outputs", {busy, done, div_zero, q_ovf, quot, rem}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, div_zero, q_ovf} == 4'b0 && quot == 0 && rem == 0,
              "R1", "post-reset outputs", {busy, done, div_zero, q_ovf, quot, rem}, 0);
        checking = 1'b1;

        // R4: unsigned 32/16
        do_op(16'h0001, 16'h86A0, 16'd7, 1'b0, 1'b1, "R4");
        do_op(16'hFFFE, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, "R4");
        do_op(16'h0000, 16'd5, 16'd9, 1'b0, 1'b1, "R4");
        // R5: signed 32/16, all sign pairs
        do_op(16'hFFFF, 16'h8000, 16'd100, 1'b1, 1'b1, "R5");
        do_op(16'h0001, 16'h0003, 16'hFFF9, 1'b1, 1'b1, "R5");
        do_op(16'hFFFE, 16'h1234, 16'hFF00, 1'b1, 1'b1, "R5");
        do_op(16'h0000, 16'h7FFF, 16'd3, 1'b1, 1'b1, "R5");
        // R6: 16-bit dividends, dvd_hi holds junk
        do_op(16'hA5A5, 16'hFFF6, 16'd3, 1'b1, 1'b0, "R6");
        do_op(16'hA5A5, 16'hFFF6, 16'd3, 1'b0, 1'b0, "R6");
        do_op(16'h1234, 16'h8000, 16'hFFFF, 1'b1, 1'b0, "R6");
        // R7: divide by zero in each mode
        do_op(16'h0012, 16'h3456, 16'h0000, 1'b0, 1'b1, "R7");
        do_op(16'h0000, 16'h8001, 16'h0000, 1'b1, 1'b0, "R7");
        // R8: overflow and the -32768 boundary
        do_op(16'h0001, 16'h0000, 16'h0001, 1'b0, 1'b1, "R8");
        do_op(16'h8000, 16'h0000, 16'hFFFF, 1'b1, 1'b1, "R8");
        do_op(16'h0000, 16'h8000, 16'h0001, 1'b1, 1'b1, "R8");
        do_op(16'hFFFF, 16'h0000, 16'h0002, 1'b1, 1'b1, "R8");
        do_op(16'h0000, 16'h8000, 16'hFFFF, 1'b1, 1'b0, "R8");

        // R3: start pulsed mid-operation with other operands
        @(negedge clk);
        cur_req = "R3";
        dvd_hi = 16'h0000; dvd_lo = 16'd1000; divisor = 16'd33;
        sgn_mode = 1'b0; wide_dvd = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        dvd_lo = 16'd77; divisor = 16'd0; sgn_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (18) @(negedge clk);

        // R2/R5/R6: mixed operations back to back
        for (int i = 0; i < 60; i++) begin
            logic [15:0] h, l, d;
            h = 16'($urandom);
            l = 16'($urandom);
            d = 16'($urandom);
            if (i % 3 == 0) h = {{12{h[15]}}, h[3:0]};
            do_op(h, l, d, i[0], i[1], i[1] ? (i[0] ? "R5" : "R4") : "R6");
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule